// File: doc/BRIEF.md
# Descriptor ring engine for frame receive and transmit

The block moves frames between byte streams and host-managed buffers through two small rings of 16-byte descriptors. Both rings sit in a descriptor memory inside the block. A host port reads and writes that memory one 32-bit word at a time. A descriptor belongs either to the engine or to the host, and a single ownership bit in its status half-word decides which. The host arms a descriptor by setting that bit. The engine clears it once it has finished with the descriptor.

On receive, an arriving frame is steered to the descriptor at the current receive index. Its bytes go out through a byte-wide buffer write port, starting at the descriptor's base address. The engine then writes back the stored length and the completion status, and moves on to the next descriptor. On transmit, the engine inspects the current transmit descriptor when a poll pulse arrives, and also at a fixed interval. If the engine owns it, the engine fetches the buffer bytes through a byte read port with one cycle of latency, emits them on a ready/valid stream, and returns the descriptor to the host. Buffer sizes are stored as negated byte counts. The engine uses the low 12 bits of the negation as the count.

Top module: `dring_engine`

## Requirements
- R1: After reset, rx_ready, tx_valid, tx_last, miss and buf_we are 0, and both ring indices are 0.
- R2: The host word address is {ring, index, word}: ring 0 is receive and ring 1 is transmit, the index is MAX_LOG bits, and the word is 2 bits. Word 0 holds the buffer base. Word 1 holds status in bits 31:16 and the size field in bits 15:0. Word 2 holds the message length in bits 15:0. Word 3 is reserved storage. hst_rdata returns the addressed word one cycle after the address is presented.
- R3: The receive ring size is 2^(ring_len_code[7:4]) and the transmit ring size is 2^(ring_len_code[15:12]), each capped at 2^MAX_LOG. Each index advances by one per completed descriptor and wraps to 0 after the last entry.
- R4: The byte capacity of a descriptor is the low 12 bits of the two's-complement negation of its size field. For example, 0xFFF0 gives 16, 0xFFF8 gives 8 and 0xF9F8 gives 1544.
- R5: On receive, byte i of a frame is written once, one cycle after it is accepted, to base+i through buf_we/buf_addr/buf_wdata.
- R6: A received frame that fits its buffer ends with word 2 = stored byte count (every byte of the stream, check bytes included) and status 0x0300 (bit 15 ownership cleared, bit 9 start and bit 8 end set). The size field is kept. Word 2 is written before the status word.
- R7: If status bit 15 of the current receive descriptor is 0, the frame is consumed with no buffer write and no descriptor change. miss pulses for exactly one cycle, and the receive index does not move.
- R8: Bytes beyond the capacity are discarded. The status becomes 0x4600 (bit 14 error, bit 10 buffer error, bit 9 start, ownership cleared) and word 2 = capacity.
- R9: A tx_poll pulse makes the engine inspect the current transmit descriptor. If bit 15 of its status is 1, the engine emits the capacity's worth of bytes from base upward, with tx_last on the final byte. It then clears bit 15 of the status, leaving the other status bits and the size field unchanged, and advances the transmit index.
- R10: With no poll pulse, the current transmit descriptor is inspected at least once every POLL_CYCLES idle cycles.
- R11: A transmit descriptor with status bit 15 at 0 produces no output and leaves the transmit index unchanged.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R13: While run is low, both indices are held at 0 and no new frame or poll is started. A frame that arrives while run is low waits with rx_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Engine enable; low clears both indices |
| ring_len_code | input | 16 | Ring size codes: transmit at 15:12, receive at 7:4 |
| hst_we | input | 1 | Host descriptor write strobe |
| hst_addr | input | MAX_LOG+3 | Host descriptor word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle latency |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_ready | output | 1 | Receive byte accepted |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte write address |
| buf_wdata | output | 8 | Buffer byte write data |
| miss | output | 1 | One-cycle pulse when a frame is dropped |
| tx_poll | input | 1 | Request to inspect the transmit ring now |
| txb_re | output | 1 | Buffer byte read strobe |
| txb_addr | output | ADDR_W | Buffer byte read address |
| txb_data | input | 8 | Read byte, valid the cycle after txb_re |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Transmit sink ready |

## Verification
Several properties are checked on every cycle by the assertions. A dropped frame never writes the buffer. miss is never wider than one cycle. The receive length word always goes out before the status word. A stalled transmit byte stays still, and tx_last never appears without tx_valid. Index steps are checked to be either +1 or a wrap to 0. Other behaviour only the scenarios can show: which descriptor a frame lands in, capacity decoding, the overflow status, leaving a host-owned descriptor untouched, ring wrap at the programmed size, and the poll timer and index reset through run.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // descriptor word select within one 16-byte entry
  localparam logic [1:0] WD_BASE = 2'd0;
  localparam logic [1:0] WD_CTL  = 2'd1;   // {status, size}
  localparam logic [1:0] WD_MLEN = 2'd2;   // {misc, message length}

  // status half-word bit positions
  localparam int SB_OWN  = 15;
  localparam int SB_ERR  = 14;
  localparam int SB_BUFF = 10;
  localparam int SB_STP  = 9;
  localparam int SB_ENP  = 8;

  localparam logic [15:0] ST_RX_OK  = (16'd1 << SB_STP) | (16'd1 << SB_ENP);
  localparam logic [15:0] ST_RX_OVF = (16'd1 << SB_ERR) | (16'd1 << SB_BUFF) | (16'd1 << SB_STP);

  localparam int LEN_W = 12;

  typedef enum logic [2:0] {
    RX_IDLE, RX_RD1, RX_RD2, RX_RECV, RX_DROP, RX_WLEN, RX_WSTAT
  } rx_st_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_RD1, TX_RD2, TX_REQ, TX_CAP, TX_OUT, TX_WB
  } tx_st_e;

  // size field holds the negated count; keep the low LEN_W bits
  function automatic logic [LEN_W-1:0] buf_count(input logic [15:0] fld);
    logic [15:0] neg;
    neg = ~fld + 16'd1;
    return neg[LEN_W-1:0];
  endfunction

endpackage

// File: rtl/dring_desc_ram.sv
module dring_desc_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [31:0]   r_wdata,
  output logic [31:0]   r_rdata,
  input  logic          t_we,
  input  logic [AW-1:0] t_addr,
  input  logic [31:0]   t_wdata,
  output logic [31:0]   t_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  // engine writes first, host write lands last on a shared address
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (t_we) mem[t_addr] <= t_wdata;
    if (h_we) mem[h_addr] <= h_wdata;
    h_rdata <= mem[h_addr];
    r_rdata <= mem[r_addr];
    t_rdata <= mem[t_addr];
  end
endmodule

// File: rtl/dring_idx.sv
module dring_idx #(
  parameter int MAX_LOG = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  input  logic [3:0]         code,
  output logic [MAX_LOG-1:0] idx
);
  logic [3:0]         eff;
  logic [MAX_LOG:0]   full;
  logic [MAX_LOG-1:0] mask;

  always_comb begin
    eff  = (code > 4'(MAX_LOG)) ? 4'(MAX_LOG) : code;
    full = ((MAX_LOG+1)'(1) << eff) - (MAX_LOG+1)'(1);
    mask = full[MAX_LOG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (adv)    idx <= (idx + MAX_LOG'(1)) & mask;
  end

  // R3: an advance steps by one or wraps to zero
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (idx == '0) || (idx == $past(idx) + MAX_LOG'(1)));
endmodule

// File: rtl/dring_rx.sv
module dring_rx
  import dring_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic [1:0]        d_wsel,
  output logic              d_we,
  output logic [31:0]       d_wdata,
  input  logic [31:0]       d_rdata,
  output logic              adv,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              miss
);
  rx_st_e             st;
  logic               own_q;
  logic [15:0]        size_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LEN_W-1:0]   cnt;
  logic [LEN_W-1:0]   cap;
  logic               ovf;
  logic               unused_stat;

  assign unused_stat = ^d_rdata[30:16];
  assign cap      = buf_count(size_q);
  assign rx_ready = (st == RX_RECV) || (st == RX_DROP);
  assign adv      = (st == RX_WSTAT);
  assign d_we     = (st == RX_WLEN) || (st == RX_WSTAT);

  always_comb begin
    case (st)
      RX_RD1:  d_wsel = WD_BASE;
      RX_WLEN: d_wsel = WD_MLEN;
      default: d_wsel = WD_CTL;
    endcase
    if (st == RX_WLEN) d_wdata = {16'h0000, {(16-LEN_W){1'b0}}, cnt};
    else               d_wdata = {(ovf ? ST_RX_OVF : ST_RX_OK), size_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      own_q     <= 1'b0;
      size_q    <= '0;
      base_q    <= '0;
      cnt       <= '0;
      ovf       <= 1'b0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      miss      <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      miss   <= 1'b0;
      case (st)
        RX_IDLE: if (run && rx_valid) st <= RX_RD1;
        RX_RD1: begin
          own_q  <= d_rdata[16+SB_OWN];
          size_q <= d_rdata[15:0];
          st     <= RX_RD2;
        end
        RX_RD2: begin
          base_q <= d_rdata[ADDR_W-1:0];
          cnt    <= '0;
          ovf    <= 1'b0;
          if (own_q) st <= RX_RECV;
          else begin
            st   <= RX_DROP;
            miss <= 1'b1;
          end
        end
        RX_RECV: if (rx_valid) begin
          if (cnt < cap) begin
            buf_we    <= 1'b1;
            buf_addr  <= base_q + ADDR_W'(cnt);
            buf_wdata <= rx_data;
            cnt       <= cnt + LEN_W'(1);
          end else begin
            ovf <= 1'b1;
          end
          if (rx_last) st <= RX_WLEN;
        end
        RX_DROP:  if (rx_valid && rx_last) st <= RX_IDLE;
        RX_WLEN:  st <= RX_WSTAT;
        RX_WSTAT: st <= RX_IDLE;
        default:  st <= RX_IDLE;
      endcase
    end
  end

  // R7: a dropped frame never reaches the buffer
  assert_drop_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (st == RX_DROP) |-> !buf_we);
  // R7: miss is a single-cycle pulse
  assert_miss_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    miss |=> !miss);
  // R5: buffer writes only follow bytes taken in the receive state
  assert_write_source_R5: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(st == RX_RECV));
  // R6: the status word is written right after the length word
  assert_len_before_stat_R6: assert property (@(posedge clk) disable iff (rst)
    (d_we && d_wsel == WD_CTL) |-> $past(d_we && d_wsel == WD_MLEN));
endmodule

// File: rtl/dring_tx.sv
module dring_tx
  import dring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int POLL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              poll,
  output logic [1:0]        d_wsel,
  output logic              d_we,
  output logic [31:0]       d_wdata,
  input  logic [31:0]       d_rdata,
  output logic              adv,
  output logic              txb_re,
  output logic [ADDR_W-1:0] txb_addr,
  input  logic [7:0]        txb_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam int TMR_W = $clog2(POLL_CYCLES + 1);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(POLL_CYCLES - 1);

  tx_st_e            st;
  logic [TMR_W-1:0]  tmr;
  logic              pend;
  logic [31:0]       ctl_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  total;
  logic [LEN_W-1:0]  cnt;

  assign adv  = (st == TX_WB);
  assign d_we = (st == TX_WB);
  assign d_wsel  = (st == TX_RD1) ? WD_BASE : WD_CTL;
  assign d_wdata = {ctl_q[31:16] & ~(16'd1 << SB_OWN), ctl_q[15:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      tmr      <= RELOAD;
      pend     <= 1'b0;
      ctl_q    <= '0;
      base_q   <= '0;
      total    <= '0;
      cnt      <= '0;
      txb_re   <= 1'b0;
      txb_addr <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      if (poll) pend <= 1'b1;
      case (st)
        TX_IDLE: begin
          if (run && (pend || poll || tmr == '0)) begin
            st   <= TX_RD1;
            pend <= 1'b0;
            tmr  <= RELOAD;
          end else if (tmr != '0) begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        TX_RD1: begin
          ctl_q <= d_rdata;
          st    <= TX_RD2;
        end
        TX_RD2: begin
          base_q <= d_rdata[ADDR_W-1:0];
          cnt    <= '0;
          total  <= buf_count(ctl_q[15:0]);
          if (!ctl_q[16+SB_OWN])                 st <= TX_IDLE;
          else if (buf_count(ctl_q[15:0]) == '0) st <= TX_WB;
          else begin
            txb_re   <= 1'b1;
            txb_addr <= d_rdata[ADDR_W-1:0];
            st       <= TX_REQ;
          end
        end
        TX_REQ: begin
          txb_re <= 1'b0;
          st     <= TX_CAP;
        end
        TX_CAP: begin
          tx_data  <= txb_data;
          tx_valid <= 1'b1;
          tx_last  <= (cnt + LEN_W'(1) == total);
          st       <= TX_OUT;
        end
        TX_OUT: if (tx_ready) begin
          tx_valid <= 1'b0;
          tx_last  <= 1'b0;
          if (tx_last) st <= TX_WB;
          else begin
            cnt      <= cnt + LEN_W'(1);
            txb_re   <= 1'b1;
            txb_addr <= base_q + ADDR_W'(cnt + LEN_W'(1));
            st       <= TX_REQ;
          end
        end
        TX_WB:   st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R12: a stalled byte stays put
  assert_hold_stall_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R9: end-of-frame marker only with a valid byte
  assert_last_valid_R9: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  // R9: one buffer read per emitted byte
  assert_read_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    txb_re |=> !txb_re);
  // R13: no inspection starts while disabled
  assert_no_start_idle_R13: assert property (@(posedge clk) disable iff (rst)
    (st == TX_IDLE && !run) |=> st == TX_IDLE);
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int MAX_LOG     = 3,
  parameter int ADDR_W      = 32,
  parameter int POLL_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [15:0]          ring_len_code,
  input  logic                 hst_we,
  input  logic [MAX_LOG+2:0]   hst_addr,
  input  logic [31:0]          hst_wdata,
  output logic [31:0]          hst_rdata,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_last,
  output logic                 rx_ready,
  output logic                 buf_we,
  output logic [ADDR_W-1:0]    buf_addr,
  output logic [7:0]           buf_wdata,
  output logic                 miss,
  input  logic                 tx_poll,
  output logic                 txb_re,
  output logic [ADDR_W-1:0]    txb_addr,
  input  logic [7:0]           txb_data,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_last,
  input  logic                 tx_ready
);
  localparam int AW = MAX_LOG + 3;

  logic [MAX_LOG-1:0] idx   [2];
  logic               adv_v [2];
  logic [3:0]         code_v[2];

  logic [1:0]  rx_wsel, tx_wsel;
  logic        rx_dwe, tx_dwe;
  logic [31:0] rx_dwdata, tx_dwdata, rx_drdata, tx_drdata;

  assign code_v[0] = ring_len_code[7:4];
  assign code_v[1] = ring_len_code[15:12];

  // one index per ring: 0 receive, 1 transmit
  for (genvar g = 0; g < 2; g++) begin : g_ring
    dring_idx #(.MAX_LOG(MAX_LOG)) i_idx (
      .clk (clk),
      .rst (rst),
      .clr (!run),
      .adv (adv_v[g]),
      .code(code_v[g]),
      .idx (idx[g])
    );
  end

  dring_desc_ram #(.AW(AW)) i_ram (
    .clk    (clk),
    .h_we   (hst_we),
    .h_addr (hst_addr),
    .h_wdata(hst_wdata),
    .h_rdata(hst_rdata),
    .r_we   (rx_dwe),
    .r_addr ({1'b0, idx[0], rx_wsel}),
    .r_wdata(rx_dwdata),
    .r_rdata(rx_drdata),
    .t_we   (tx_dwe),
    .t_addr ({1'b1, idx[1], tx_wsel}),
    .t_wdata(tx_dwdata),
    .t_rdata(tx_drdata)
  );

  dring_rx #(.ADDR_W(ADDR_W)) i_rx (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .rx_ready (rx_ready),
    .d_wsel   (rx_wsel),
    .d_we     (rx_dwe),
    .d_wdata  (rx_dwdata),
    .d_rdata  (rx_drdata),
    .adv      (adv_v[0]),
    .buf_we   (buf_we),
    .buf_addr (buf_addr),
    .buf_wdata(buf_wdata),
    .miss     (miss)
  );

  dring_tx #(.ADDR_W(ADDR_W), .POLL_CYCLES(POLL_CYCLES)) i_tx (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .poll    (tx_poll),
    .d_wsel  (tx_wsel),
    .d_we    (tx_dwe),
    .d_wdata (tx_dwdata),
    .d_rdata (tx_drdata),
    .adv     (adv_v[1]),
    .txb_re  (txb_re),
    .txb_addr(txb_addr),
    .txb_data(txb_data),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_last (tx_last),
    .tx_ready(tx_ready)
  );

  // R1: outputs are quiet in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !rx_ready && !tx_valid && !buf_we && !miss);
endmodule

// File: tb/test_dring_engine.sv
module test_dring_engine;
  localparam int POLL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] ring_len_code = 16'h1020;
  logic        hst_we = 1'b0;
  logic [5:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        buf_we, miss, txb_re, tx_valid, tx_last;
  logic [31:0] buf_addr, txb_addr;
  logic [7:0]  buf_wdata, tx_data, txb_q = '0;
  logic        tx_poll = 1'b0, tx_ready = 1'b1;

  always #2.5 clk = ~clk;

  dring_engine #(.MAX_LOG(3), .ADDR_W(32), .POLL_CYCLES(POLL)) i_dring_engine (
    .clk(clk), .rst(rst), .run(run), .ring_len_code(ring_len_code),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .miss(miss),
    .tx_poll(tx_poll), .txb_re(txb_re), .txb_addr(txb_addr), .txb_data(txb_q),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int checks = 0, fails = 0, miss_cnt = 0, tx_hs = 0;
  logic [39:0] exp_buf[$];
  logic [8:0]  exp_tx[$];
  logic [7:0]  bmem [0:1023];
  bit          bp_en = 1'b0;
  bit          stall_q = 1'b0;
  logic [8:0]  stall_v = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] da(input bit ring, input int ix, input int w);
    return {ring, 3'(ix), 2'(w)};
  endfunction

  // buffer model for transmit reads: one cycle latency
  always @(posedge clk) if (txb_re) txb_q <= bmem[txb_addr[9:0]];

  // transmit sink ready pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      tx_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
    end
  end

  // monitors: buffer writes, transmit bytes, miss pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (buf_we) begin
        if (exp_buf.size() == 0) chk(0, "R5 unexpected buffer write", buf_addr, 0);
        else begin
          logic [39:0] e;
          e = exp_buf.pop_front();
          chk({buf_addr, buf_wdata} == e, "R5 buffer write", {buf_addr[23:0], buf_wdata}, e[31:0]);
        end
      end
      if (stall_q)
        chk(tx_valid && {tx_last, tx_data} == stall_v, "R12 stalled byte held",
            {tx_valid, tx_last, tx_data}, {1'b1, stall_v});
      stall_q = tx_valid && !tx_ready;
      stall_v = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        tx_hs++;
        if (exp_tx.size() == 0) chk(0, "R11 unexpected transmit byte", {tx_last, tx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          chk({tx_last, tx_data} == e, "R9 transmit byte", {tx_last, tx_data}, e);
        end
      end
      if (miss) miss_cnt++;
    end
  end

  task automatic hw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 1'b0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); hst_addr = a;
    @(negedge clk); d = hst_rdata;
  endtask

  task automatic send_frame(input int n, input int first, input int stored, input logic [31:0] base);
    for (int i = 0; i < stored; i++) exp_buf.push_back({base + 32'(i), 8'(first + 3*i)});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(first + 3*i); rx_last = (i == n-1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_tx(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) exp_tx.push_back({(i == n-1), bmem[base[9:0] + 10'(i)]});
  endtask

  task automatic pulse_poll();
    @(negedge clk); tx_poll = 1'b1;
    @(negedge clk); tx_poll = 1'b0;
  endtask

  task automatic wait_tx(input int lim, input string tag);
    for (int k = 0; k < lim && exp_tx.size() != 0; k++) @(negedge clk);
    chk(exp_tx.size() == 0, tag, exp_tx.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hs0;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i*7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!rx_ready && !tx_valid && !tx_last && !miss && !buf_we, "R1 outputs after reset",
        {rx_ready, tx_valid, tx_last, miss, buf_we}, 0);

    for (int i = 0; i < 8; i++) for (int w = 0; w < 4; w++) hw(da(1, i, w), 32'h0);
    // R2 reserved word storage and read latency
    hw(da(0, 5, 3), 32'hA5C3_0F1E);
    hr(da(0, 5, 3), v);
    chk(v == 32'hA5C3_0F1E, "R2 host word readback", v, 32'hA5C3_0F1E);

    hw(da(0,0,0), 32'h100); hw(da(0,0,1), 32'h8000_FFF0);
    hw(da(0,1,0), 32'h200); hw(da(0,1,1), 32'h8000_FFF8);
    hw(da(0,2,0), 32'h300); hw(da(0,2,1), 32'h0000_FFF0);
    hw(da(0,3,0), 32'h340); hw(da(0,3,1), 32'h8000_F9F8);
    run = 1'b1;

    // R5 R6 R4: 10 bytes into 16-byte buffer, first descriptor after reset (R1 index 0)
    send_frame(10, 8'h11, 10, 32'h100);
    hr(da(0,0,1), v); chk(v == 32'h0300_FFF0, "R6 status after fit frame", v, 32'h0300_FFF0);
    hr(da(0,0,2), v); chk(v == 32'h0000_000A, "R6 message length", v, 32'h0000_000A);

    // R8 overflow: 12 bytes into 8-byte buffer
    send_frame(12, 8'h40, 8, 32'h200);
    hr(da(0,1,1), v); chk(v == 32'h4600_FFF8, "R8 overflow status", v, 32'h4600_FFF8);
    hr(da(0,1,2), v); chk(v == 32'h0000_0008, "R8 stored length equals capacity", v, 8);

    // R7 host-owned descriptor
    send_frame(5, 8'h70, 0, 32'h300);
    chk(miss_cnt == 1, "R7 miss pulse count", miss_cnt, 1);
    hr(da(0,2,1), v); chk(v == 32'h0000_FFF0, "R7 descriptor untouched", v, 32'h0000_FFF0);
    hw(da(0,2,1), 32'h8000_FFF0);
    send_frame(6, 8'h90, 6, 32'h300);
    hr(da(0,2,2), v); chk(v == 32'h0000_0006, "R7 index held, frame lands in same entry", v, 6);

    // R4 0xF9F8 decodes to 1544
    send_frame(20, 8'h05, 20, 32'h340);
    hr(da(0,3,1), v); chk(v == 32'h0300_F9F8, "R4 large buffer status", v, 32'h0300_F9F8);

    // R3 receive wrap on 4-entry ring
    hw(da(0,0,1), 32'h8000_FFF0);
    send_frame(3, 8'hC0, 3, 32'h100);
    hr(da(0,0,2), v); chk(v == 32'h0000_0003, "R3 receive ring wrap", v, 3);

    // R9 poll-driven transmit
    hw(da(1,0,0), 32'h040); hw(da(1,1,0), 32'h080);
    expect_tx(32'h040, 5);
    hw(da(1,0,1), 32'h8300_FFFB);
    pulse_poll();
    wait_tx(100, "R9 poll transmit complete");
    hr(da(1,0,1), v); chk(v == 32'h0300_FFFB, "R9 ownership returned", v, 32'h0300_FFFB);

    // R10 timer-driven transmit
    expect_tx(32'h080, 3);
    hw(da(1,1,1), 32'h8300_FFFD);
    wait_tx(POLL + 60, "R10 timer transmit complete");
    hr(da(1,1,1), v); chk(v == 32'h0300_FFFD, "R10 ownership returned", v, 32'h0300_FFFD);

    // R3 transmit wrap on 2-entry ring, R12 backpressure
    bp_en = 1'b1;
    expect_tx(32'h040, 4);
    hw(da(1,0,1), 32'h8300_FFFC);
    pulse_poll();
    wait_tx(200, "R3 transmit ring wrap");
    bp_en = 1'b0;

    // R11 host-owned transmit descriptor
    hs0 = tx_hs;
    pulse_poll();
    repeat (30) @(negedge clk);
    chk(tx_hs == hs0, "R11 no output for host-owned entry", tx_hs, hs0);
    expect_tx(32'h080, 2);
    hw(da(1,1,1), 32'h8300_FFFE);
    pulse_poll();
    wait_tx(100, "R11 index held on host-owned entry");

    // R13 run low clears indices
    hw(da(0,0,1), 32'h8000_FFF0);
    @(negedge clk); run = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    send_frame(7, 8'h21, 7, 32'h100);
    hr(da(0,0,2), v); chk(v == 32'h0000_0007, "R13 receive index cleared", v, 7);
    chk(miss_cnt == 1, "R13 no extra miss", miss_cnt, 1);
    chk(exp_buf.size() == 0, "R5 all buffer writes seen", exp_buf.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule